// File: doc/BRIEF.md
# Synchronous Serial Port with Selectable Frame-Sync Modes

This block moves parallel words onto and off a synchronous serial line. Software writes words into a four-entry transmit queue through a small register port. The block shifts each word out most-significant bit first on one data pin. At the same time it assembles incoming bits from a second data pin into words and places them in a four-entry receive queue, where software reads them back. Timing comes from an external bit clock. Separate transmit and receive frame-sync inputs mark where a transfer begins.

A control register sets the word length to 8 or 16 bits and selects one of two frame-sync modes. In streaming mode a single sync pulse starts a transfer and the words that follow run back to back. The transfer ends when the transmit queue runs dry or the receive queue fills. In gated mode each word waits for its own sync pulse. The control register also holds the two interrupt enables and a transmit-only bit. Setting the transmit-only bit turns the receiver off and forces streaming mode. The transmit interrupt is raised while the transmit queue is empty, and the receive interrupt while the receive queue is full.

Top module: `ssp_port`

## Requirements
- R1: After reset the control register (address 0) reads 0. The status register (address 3) reads 0x5: bit 0 = transmit queue empty, bit 1 = transmit queue full, bit 2 = receive queue empty, bit 3 = receive queue full. Both interrupts are low and `sd_out` is 0.
- R2: A sync pulse is sampled on a rising `sck` edge. The transmitter drives the first data bit on the next falling edge and changes data only on falling edges. The receiver samples its first bit on the rising edge after the sync edge. Words travel most-significant bit first.
- R3: Control bit 0 selects the word length: 0 for 8 bits, 1 for 16 bits. For 8-bit words only the low byte of a written word is sent, and received words read back with their upper byte at zero.
- R4: With control bit 1 at 0 (streaming mode), one sync pulse starts a transfer, and the next queued word follows the previous one with no idle bit.
- R5: In streaming mode the transmit transfer ends when the transmit queue is empty. A word written later is not sent until a new sync pulse arrives, and `sd_out` stays 0 while idle.
- R6: In streaming mode the receiver stops once a received word fills the receive queue. Bits arriving after that, without a new sync, are not stored.
- R7: With control bit 1 at 1 (gated mode), each word needs its own sync pulse. After one word both directions go idle until the next pulse.
- R8: Writes to address 1 push into the transmit queue and reads at address 2 pop the receive queue. Each queue holds 4 words. A write to a full transmit queue and a read from an empty receive queue are both ignored.
- R9: `irq_tx` equals control bit 2 AND transmit queue empty. `irq_rx` equals control bit 3 AND receive queue full.
- R10: Control bit 4 selects transmit-only. A write that sets bits 4 and 1 together stores bit 1 as 0, and while bit 4 is set the receiver ignores sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on the address |
| sck | input | 1 | Serial bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| rx_fs | input | 1 | Receive frame sync |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |

## Verification
The hardest cases to reach are the end-of-transfer conditions of streaming mode. One is the receiver stopping on the exact word that fills its queue while serial data keeps arriving. The other is the transmitter going silent after its queue drains and then waiting for a fresh sync even though a new word has been written. The stimulus runs one long streaming transfer that supplies five receive words against a four-entry queue and three transmit words. It then writes a fourth transmit word and clocks idle bit periods with no sync before giving one. A second sequence fills the transmit queue past capacity and streams it out, which shows the dropped fifth word at the serial pin.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic txonly;
    logic rie;
    logic tie;
    logic interval;
    logic wlen16;
  } ssp_ctl_t;

  // Index of the last bit in a word, used as the bit-counter load value.
  function automatic logic [3:0] last_bit_idx(input logic wide);
    return wide ? 4'd15 : 4'd7;
  endfunction

  // Left-align a word so the first bit to send sits at the top.
  function automatic logic [WORD_W-1:0] tx_align(input logic [WORD_W-1:0] w, input logic wide);
    return wide ? w : {w[7:0], 8'h00};
  endfunction

  // Clear the unused upper byte of a received narrow word.
  function automatic logic [WORD_W-1:0] rx_trim(input logic [WORD_W-1:0] w, input logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == $past(count)));
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              fs,
  input  logic              interval,
  input  logic              wide,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_dout,
  output logic              fifo_pop,
  output logic              load_evt,
  output logic              sd_out
);
  logic              armed, active;
  logic [3:0]        cnt;
  logic [WORD_W-1:0] sh;
  logic              word_end, chain;

  assign word_end = active && (cnt == 4'd0);
  assign chain    = word_end && !interval && !fifo_empty;
  assign load_evt = sck_fall && (armed || chain);
  assign fifo_pop = load_evt;
  assign sd_out   = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      if (sck_rise && !active && !armed && fs && !fifo_empty)
        armed <= 1'b1;
      if (sck_fall) begin
        if (armed || chain) begin
          sh     <= tx_align(fifo_dout, wide);
          cnt    <= last_bit_idx(wide);
          active <= 1'b1;
          armed  <= 1'b0;
        end else if (word_end) begin
          active <= 1'b0;
          sh     <= '0;
        end else if (active) begin
          sh  <= sh << 1;
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5
  tx_load_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !fifo_empty);

  // R7
  tx_interval_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && word_end && interval && !armed) |=> !active);
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck_rise,
  input  logic                       fs,
  input  logic                       sd_in,
  input  logic                       interval,
  input  logic                       wide,
  input  logic                       enable,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       push,
  output logic [WORD_W-1:0]          push_data
);
  localparam int CW = $clog2(DEPTH+1);

  logic              active;
  logic [3:0]        cnt;
  logic [WORD_W-1:0] sh, sh_next;
  logic              stop_after;

  assign sh_next    = {sh[WORD_W-2:0], sd_in};
  assign push       = sck_rise && active && (cnt == 4'd0);
  assign push_data  = rx_trim(sh_next, wide);
  assign stop_after = interval || (fifo_count >= CW'(DEPTH-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else if (sck_rise) begin
      if (active) begin
        sh <= sh_next;
        if (cnt == 4'd0) begin
          if (stop_after) active <= 1'b0;
          else            cnt    <= last_bit_idx(wide);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (fs && enable) begin
        active <= 1'b1;
        cnt    <= last_bit_idx(wide);
        sh     <= '0;
      end
    end
  end

  // R6
  rx_full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !interval && (fifo_count == CW'(DEPTH-1))) |=> !active);
endmodule

// File: rtl/ssp_port.sv
`timescale 1ns/1ps
module ssp_port
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sck,
  input  logic        tx_fs,
  input  logic        rx_fs,
  input  logic        sd_in,
  output logic        sd_out,
  output logic        irq_tx,
  output logic        irq_rx
);
  localparam int CW = $clog2(FIFO_DEPTH+1);
  localparam logic [1:0] A_CTL = 2'd0, A_TXD = 2'd1, A_RXD = 2'd2, A_STS = 2'd3;

  ssp_ctl_t          ctl;
  logic              sck_q, sck_rise, sck_fall;
  logic              tx_push, tx_pop, tx_empty, tx_full, tx_load;
  logic [WORD_W-1:0] tx_dout;
  logic [CW-1:0]     tx_count;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [WORD_W-1:0] rx_din, rx_dout;
  logic [CW-1:0]     rx_count;

  assign sck_rise = sck && !sck_q;
  assign sck_fall = !sck && sck_q;
  assign tx_push  = reg_wr && (reg_addr == A_TXD);
  assign rx_pop   = reg_rd && (reg_addr == A_RXD);
  assign irq_tx   = ctl.tie && tx_empty;
  assign irq_rx   = ctl.rie && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ctl   <= '0;
    end else begin
      sck_q <= sck;
      if (reg_wr && reg_addr == A_CTL)
        ctl <= {reg_wdata[4], reg_wdata[3], reg_wdata[2],
                reg_wdata[1] & ~reg_wdata[4], reg_wdata[0]};
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {11'd0, ctl};
      A_RXD:   reg_rdata = rx_dout;
      A_STS:   reg_rdata = {12'd0, rx_full, rx_empty, tx_full, tx_empty};
      default: reg_rdata = '0;
    endcase
  end

  ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full), .count(tx_count));

  ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full), .count(rx_count));

  ssp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .fs(tx_fs), .interval(ctl.interval), .wide(ctl.wlen16),
    .fifo_empty(tx_empty), .fifo_dout(tx_dout), .fifo_pop(tx_pop),
    .load_evt(tx_load), .sd_out(sd_out));

  ssp_rx #(.DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .fs(rx_fs), .sd_in(sd_in),
    .interval(ctl.interval), .wide(ctl.wlen16), .enable(!ctl.txonly),
    .fifo_count(rx_count), .push(rx_push), .push_data(rx_din));

  // R10
  txonly_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.txonly |-> !ctl.interval);

  // R9
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> tx_empty);

  // R9
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> rx_full);

  // R2
  tx_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !tx_load) |=> $stable(sd_out));
endmodule

// File: tb/ssp_port_tb.sv
`timescale 1ns/1ps
module ssp_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck = 1'b1, tx_fs = 1'b0, rx_fs = 1'b0, sd_in = 1'b0;
  logic        sd_out, irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;
  bit got_q[$];
  bit exp_q[$];
  bit din_q[$];

  always #2.5 clk = ~clk;

  ssp_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .tx_fs(tx_fs), .rx_fs(rx_fs), .sd_in(sd_in),
    .sd_out(sd_out), .irq_tx(irq_tx), .irq_rx(irq_rx));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic exp_word(input logic [15:0] w, input int n);
    for (int i = n-1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask
  task automatic exp_pad(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
  endtask
  task automatic din_word(input logic [15:0] w, input int n);
    for (int i = n-1; i >= 0; i--) din_q.push_back(w[i]);
  endtask
  task automatic din_pad(input int n);
    for (int i = 0; i < n; i++) din_q.push_back(1'b0);
  endtask

  // One slot = one bit period: falling edge, low phase, sample, rising edge.
  task automatic run_slots(input int n, input int tx_sync, input int rx_sync);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      sck   = 1'b0;
      tx_fs = (s == tx_sync);
      rx_fs = (s == rx_sync);
      sd_in = (din_q.size() > 0) ? din_q.pop_front() : 1'b0;
      repeat (3) @(negedge clk);
      got_q.push_back(sd_out);
      @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
    tx_fs = 1'b0; rx_fs = 1'b0; sd_in = 1'b0;
    din_q.delete();
  endtask

  task automatic check_stream(input string req);
    logic [63:0] a, e;
    a = '0; e = '0;
    for (int i = 0; i < got_q.size(); i++) begin
      a = {a[62:0], got_q[i]};
      e = {e[62:0], (i < exp_q.size()) ? exp_q[i] : 1'b0};
    end
    chk(req, a, e);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    rd(2'd0, v); chk("R1 ctl", v, 16'h0000);
    rd(2'd3, v); chk("R1 status", v, 16'h0005);
    chk("R1 irqs/sd_out", {irq_tx, irq_rx, sd_out}, 3'b000);

    // R9: tx interrupt follows enable and empty queue
    wr(2'd0, 16'h000C);
    @(negedge clk); chk("R9 irq_tx empty", irq_tx, 1'b1);
    wr(2'd1, 16'hA55A); wr(2'd1, 16'hFF81); wr(2'd1, 16'h12C7);
    @(negedge clk); chk("R9 irq_tx busy", irq_tx, 1'b0);

    // R2 R3 R4 R6: streaming 8-bit, one sync, rx gets 5 bytes offered, keeps 4
    exp_pad(1); exp_word(16'h5A, 8); exp_word(16'h81, 8); exp_word(16'hC7, 8);
    din_pad(1); din_word(16'hB4, 8); din_word(16'h6E, 8); din_word(16'h01, 8);
    din_word(16'hF0, 8); din_word(16'h99, 8);
    run_slots(42, 0, 0);
    check_stream("R4 R3 R2 streaming tx");
    rd(2'd3, v); chk("R6 status rx full tx empty", v, 16'h0009);
    chk("R9 both irqs", {irq_tx, irq_rx}, 2'b11);
    rd(2'd2, v); chk("R3 R6 rx word0", v, 16'h00B4);
    rd(2'd2, v); chk("R6 rx word1", v, 16'h006E);
    rd(2'd2, v); chk("R6 rx word2", v, 16'h0001);
    rd(2'd2, v); chk("R6 rx word3", v, 16'h00F0);
    rd(2'd3, v); chk("R6 R9 status drained", v, 16'h0005);
    chk("R9 irq_rx low", irq_rx, 1'b0);
    rd(2'd2, v);
    rd(2'd3, v); chk("R8 empty read ignored", v, 16'h0005);

    // R5: after draining, no output until a new sync
    wr(2'd1, 16'h77C3);
    run_slots(12, -1, -1);
    check_stream("R5 idle without sync");
    rd(2'd3, v); chk("R5 word still queued", v, 16'h0004);
    exp_pad(1); exp_word(16'hC3, 8);
    run_slots(10, 0, -1);
    check_stream("R5 R2 restart with sync");

    // R7: gated 16-bit mode
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'hBEEF); wr(2'd1, 16'h1234);
    exp_pad(1); exp_word(16'hBEEF, 16);
    din_pad(1); din_word(16'h9C3A, 16); din_word(16'hFFFF, 16);
    run_slots(40, 0, 0);
    check_stream("R7 R3 gated one word");
    rd(2'd2, v); chk("R7 R3 rx wide word", v, 16'h9C3A);
    rd(2'd3, v); chk("R7 one rx word, tx waiting", v, 16'h0004);
    exp_pad(3); exp_word(16'h1234, 16);
    run_slots(20, 2, -1);
    check_stream("R7 second word on second sync");

    // R8: fifth write to full tx queue is dropped
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0011); wr(2'd1, 16'h0022); wr(2'd1, 16'h0033);
    wr(2'd1, 16'h0044); wr(2'd1, 16'h0055);
    rd(2'd3, v); chk("R8 tx full", v, 16'h0006);
    exp_pad(1); exp_word(16'h11, 8); exp_word(16'h22, 8);
    exp_word(16'h33, 8); exp_word(16'h44, 8);
    run_slots(40, 0, -1);
    check_stream("R8 R4 four words only");
    rd(2'd3, v); chk("R8 tx drained", v, 16'h0005);

    // R10: transmit-only forces streaming, disables receiver
    wr(2'd0, 16'h0012);
    rd(2'd0, v); chk("R10 interval forced 0", v, 16'h0010);
    din_pad(1); din_word(16'hA5, 8);
    run_slots(10, -1, 0);
    got_q.delete();
    rd(2'd3, v); chk("R10 receiver off", v, 16'h0005);

    finish_run();
  end
endmodule